// File: doc/BRIEF.md
# Pseudo-SRAM Host Interface Controller

This block sits between a synchronous request port inside the chip and an external asynchronous pseudo-static RAM of 512K sixteen-bit words. A requester presents an address, write data, two byte enables and a read/write flag under a valid/ready handshake. The controller turns each accepted request into one timed read or write cycle on the memory pins. A read returns its word with a one-cycle valid pulse. All memory strobes come straight from flops, and every timing figure is a cycle count given as a parameter.

The memory refreshes its cells only while it is deselected, and it loses data if it stays selected for longer than 15 µs. A select-window counter tracks how long the chip has been selected. Back-to-back requests share one select period only while the next access, with its closing cycle, still fits under the limit. Otherwise the controller first opens a deselect gap. After reset the controller keeps the chip deselected and holds ready low for the power-up wait.

The state machine has seven states. INIT leads to IDLE when the power-up count ends. IDLE moves to RD or WR when a request arrives. RD leads to LINK when the access count ends. WR leads to WREC when the strobe count ends. WREC always leads to LINK. LINK moves to RD or WR when a request is waiting and the window has room, and to GAP in every other case. GAP returns to IDLE when the gap count ends.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is held, and for INIT_CYC clock cycles after it is released, the pins show mem_ce_n=1, mem_ce2=0, mem_oe_n=1, mem_we_n=1, mem_lb_n=mem_ub_n=1 and mem_dq_oe=0, and req_ready is 0. In the next cycle req_ready is 1.
- R2: In a read, mem_oe_n is low with mem_we_n high for exactly RD_CYC cycles. The word on mem_dq_i in the last of those cycles appears on rsp_rdata, with rsp_valid high for one cycle in the cycle right after it.
- R3: In a write, mem_we_n is low for exactly WR_CYC cycles. One cycle then follows with mem_we_n, mem_lb_n and mem_ub_n high while mem_dq_oe stays 1 and data and address are held. mem_dq_oe is 1 only in those WR_CYC+1 cycles.
- R4: Byte lanes are active low. req_be[0] drives mem_lb_n (data bits 7:0) and req_be[1] drives mem_ub_n (bits 15:8). A single-lane write leaves the other byte of the stored word unchanged.
- R5: mem_dq_oe and mem_oe_n=0 never occur in the same cycle. mem_dq_oe rises only after a cycle in which mem_oe_n was already 1.
- R6: The chip (mem_ce_n=0 and mem_ce2=1) is never selected for more than SEL_MAX_CYC consecutive cycles. A request that would not fit waits through a deselect gap and is then served.
- R7: Every deselect period lasts at least GAP_CYC cycles, and req_ready is 0 in its first cycle.
- R8: A request already waiting when an access ends is accepted without deselecting the chip, as long as the window has room.
- R9: mem_addr and mem_dq_o stay constant for as long as mem_we_n is low.
- R10: mem_we_n and mem_oe_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 16 | Read data |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_lb_n | output | 1 | Active-low low-byte select |
| mem_ub_n | output | 1 | Active-low high-byte select |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | 16 | Data from memory |

## Verification
The bench builds the controller with INIT_CYC=20, RD_CYC=4, WR_CYC=3, GAP_CYC=2 and SEL_MAX_CYC=30, in place of the defaults of thousands of cycles. With these values the power-up wait fits in a few dozen cycles. A burst of twelve writes fills the select window exactly twice, so the forced gap and its position can be predicted to the cycle. The two-cycle gap and the four-cycle read also make the gap length and the strobe widths visible as exact counts.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_WREC,
        ST_LINK,
        ST_GAP
    } psram_state_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_timer.sv
module psram_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/psram_selwin.sv
module psram_selwin #(
    parameter int LIMIT = 1800,
    parameter int COST  = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_on,
    output logic room
);

    localparam int CW = $clog2(LIMIT + COST + 1) + 1;

    logic [CW-1:0] sel_cnt;

    // cycles the chip has spent selected so far in this select period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_cnt <= '0;
        end else if (!sel_on) begin
            sel_cnt <= '0;
        end else if (sel_cnt != CW'(LIMIT)) begin
            sel_cnt <= sel_cnt + 1'b1;
        end
    end

    assign room = (sel_cnt + CW'(COST)) <= CW'(LIMIT);

endmodule

// File: rtl/psram_rdcap.sv
module psram_rdcap #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] dq_i,
    output logic [W-1:0] rdata,
    output logic         rvalid
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture;
            if (capture) begin
                rdata <= dq_i;
            end
        end
    end

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int INIT_CYC    = 6250,
    parameter int RD_CYC      = 7,
    parameter int WR_CYC      = 6,
    parameter int GAP_CYC     = 1,
    parameter int SEL_MAX_CYC = 1800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_i
);

    localparam int ACC_MAX  = int'(max2(RD_CYC, WR_CYC + 1));
    localparam int ACC_COST = ACC_MAX + 2;
    localparam int TMAX     = int'(max2(max2(INIT_CYC, RD_CYC), max2(WR_CYC, GAP_CYC)));
    localparam int TW       = $clog2(TMAX + 1);

    psram_state_e state, state_nx;
    logic [TW-1:0] tmr;
    logic          room;
    logic          sel_on;
    logic          accept;
    logic          capture;

    assign sel_on  = (state == ST_RD) || (state == ST_WR) ||
                     (state == ST_WREC) || (state == ST_LINK);
    assign req_ready = (state == ST_IDLE) || ((state == ST_LINK) && room);
    assign accept  = req_valid && req_ready;
    assign capture = (state == ST_RD) && (state_nx == ST_LINK);

    psram_timer #(.W(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_nx != state),
        .cnt   (tmr)
    );

    psram_selwin #(.LIMIT(SEL_MAX_CYC), .COST(ACC_COST)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_on (sel_on),
        .room   (room)
    );

    psram_rdcap #(.W(16)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .dq_i    (mem_dq_i),
        .rdata   (rsp_rdata),
        .rvalid  (rsp_valid)
    );

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INIT: if (tmr == TW'(INIT_CYC - 1)) state_nx = ST_IDLE;
            ST_IDLE: if (req_valid) state_nx = req_write ? ST_WR : ST_RD;
            ST_RD:   if (tmr == TW'(RD_CYC - 1)) state_nx = ST_LINK;
            ST_WR:   if (tmr == TW'(WR_CYC - 1)) state_nx = ST_WREC;
            ST_WREC: state_nx = ST_LINK;
            ST_LINK: begin
                if (req_valid && room) state_nx = req_write ? ST_WR : ST_RD;
                else                   state_nx = ST_GAP;
            end
            ST_GAP:  if (tmr == TW'(GAP_CYC - 1)) state_nx = ST_IDLE;
            default: state_nx = ST_INIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_INIT;
        else        state <= state_nx;
    end

    // registered pin outputs, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_ce2   <= 1'b0;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_addr  <= '0;
            mem_dq_o  <= '0;
            mem_dq_oe <= 1'b0;
        end else begin
            if (accept) begin
                mem_addr <= req_addr;
                mem_dq_o <= req_wdata;
                mem_lb_n <= ~req_be[0];
                mem_ub_n <= ~req_be[1];
            end
            unique case (state_nx)
                ST_RD: begin
                    mem_ce_n  <= 1'b0;
                    mem_ce2   <= 1'b1;
                    mem_oe_n  <= 1'b0;
                    mem_we_n  <= 1'b1;
                    mem_dq_oe <= 1'b0;
                end
                ST_WR: begin
                    mem_ce_n  <= 1'b0;
                    mem_ce2   <= 1'b1;
                    mem_oe_n  <= 1'b1;
                    mem_we_n  <= 1'b0;
                    mem_dq_oe <= 1'b1;
                end
                ST_WREC: begin
                    mem_ce_n  <= 1'b0;
                    mem_ce2   <= 1'b1;
                    mem_oe_n  <= 1'b1;
                    mem_we_n  <= 1'b1;
                    mem_lb_n  <= 1'b1;
                    mem_ub_n  <= 1'b1;
                    mem_dq_oe <= 1'b1;
                end
                ST_LINK: begin
                    mem_ce_n  <= 1'b0;
                    mem_ce2   <= 1'b1;
                    mem_oe_n  <= 1'b1;
                    mem_we_n  <= 1'b1;
                    mem_lb_n  <= 1'b1;
                    mem_ub_n  <= 1'b1;
                    mem_dq_oe <= 1'b0;
                end
                default: begin
                    mem_ce_n  <= 1'b1;
                    mem_ce2   <= 1'b0;
                    mem_oe_n  <= 1'b1;
                    mem_we_n  <= 1'b1;
                    mem_lb_n  <= 1'b1;
                    mem_ub_n  <= 1'b1;
                    mem_dq_oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
    parameter int ADDR_W      = 19,
    parameter int INIT_CYC    = 6250,
    parameter int GAP_CYC     = 1,
    parameter int SEL_MAX_CYC = 1800
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_ce_n,
    input logic              mem_ce2,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       mem_dq_o,
    input logic              mem_dq_oe
);

    logic        sel;
    logic [31:0] sel_run;
    logic [31:0] gap_run;
    logic [31:0] init_cnt;

    assign sel = !mem_ce_n && mem_ce2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_run  <= '0;
            gap_run  <= 32'(GAP_CYC);
            init_cnt <= '0;
        end else begin
            sel_run <= sel ? sel_run + 1 : '0;
            gap_run <= sel ? '0 : gap_run + 1;
            if (init_cnt != 32'(INIT_CYC)) init_cnt <= init_cnt + 1;
        end
    end

    assert_init_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (init_cnt < 32'(INIT_CYC)) |-> (mem_ce_n && !mem_ce2 && !req_ready));

    assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_wr_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));

    assert_sel_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> (sel_run < 32'(SEL_MAX_CYC)));

    assert_gap_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel) |-> (gap_run >= 32'(GAP_CYC)));

    assert_gap_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && $past(sel)) |-> !req_ready);

    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

endmodule

bind psram_ctrl psram_ctrl_chk #(
    .ADDR_W      (ADDR_W),
    .INIT_CYC    (INIT_CYC),
    .GAP_CYC     (GAP_CYC),
    .SEL_MAX_CYC (SEL_MAX_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_ce_n  (mem_ce_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_psram_ctrl.sv
`timescale 1ns/1ps
module sim_psram_ctrl;

    localparam int AW   = 19;
    localparam int INIT = 20;
    localparam int RDC  = 4;
    localparam int WRC  = 3;
    localparam int GAPC = 2;
    localparam int SELM = 30;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          req_valid, req_ready, req_write;
    logic [AW-1:0] req_addr;
    logic [15:0]   req_wdata;
    logic [1:0]    req_be;
    logic          rsp_valid;
    logic [15:0]   rsp_rdata;
    logic          mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_dq_o;
    logic          mem_dq_oe;
    logic [15:0]   mem_dq_i;

    psram_ctrl #(
        .ADDR_W(AW), .INIT_CYC(INIT), .RD_CYC(RDC), .WR_CYC(WRC),
        .GAP_CYC(GAPC), .SEL_MAX_CYC(SELM)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- pin-level memory model ----------------
    logic [15:0] pmem [int];
    function automatic logic [15:0] prd(int a);
        return pmem.exists(a) ? pmem[a] : 16'h0000;
    endfunction

    always @(posedge clk) begin
        logic [15:0] w;
        if (rst_n && !mem_ce_n && mem_ce2 && !mem_we_n && mem_dq_oe) begin
            w = prd(int'(mem_addr));
            if (!mem_lb_n) w[7:0]  = mem_dq_o[7:0];
            if (!mem_ub_n) w[15:8] = mem_dq_o[15:8];
            pmem[int'(mem_addr)] = w;
        end
    end

    always @(negedge clk) begin
        logic [15:0] w;
        if (!mem_ce_n && mem_ce2 && !mem_oe_n && mem_we_n) begin
            w = prd(int'(mem_addr));
            mem_dq_i <= {mem_ub_n ? 8'hEE : w[15:8], mem_lb_n ? 8'hEE : w[7:0]};
        end else begin
            mem_dq_i <= 16'hEEEE;
        end
    end

    // ---------------- request-level scoreboard ----------------
    logic [15:0] smem [int];
    logic [15:0] rq [$];

    function automatic logic [15:0] exp_read(int a, logic [1:0] be);
        logic [15:0] w;
        w = smem.exists(a) ? smem[a] : 16'h0000;
        return {be[1] ? w[15:8] : 8'hEE, be[0] ? w[7:0] : 8'hEE};
    endfunction

    function automatic void sb_write(int a, logic [15:0] d, logic [1:0] be);
        logic [15:0] w;
        w = smem.exists(a) ? smem[a] : 16'h0000;
        if (be[0]) w[7:0]  = d[7:0];
        if (be[1]) w[15:8] = d[15:8];
        smem[a] = w;
    endfunction

    task automatic issue(bit wr, int a, logic [15:0] d, logic [1:0] be);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(a);
        req_wdata = d;
        req_be    = be;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        if (wr) sb_write(a, d, be);
        else    rq.push_back(exp_read(a, be));
    endtask

    task automatic idle(int n);
        if (n > 0) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (n > 1) repeat (n - 1) @(negedge clk);
        end
    endtask

    // ---------------- response monitor ----------------
    always @(negedge clk) begin
        logic [15:0] e;
        if (rst_n && rsp_valid) begin
            if (rq.size() == 0) begin
                chk(1'b0, "R2", "unexpected rsp_valid", 1, 0);
            end else begin
                e = rq.pop_front();
                chk(rsp_rdata == e, "R2", "read data", int'(rsp_rdata), int'(e));
            end
        end
    end

    // ---------------- pin monitor ----------------
    int  sel_run = 0, desel_run = 0, we_run = 0, oe_run = 0;
    int  sel_starts = 0, max_run = 0;
    int  v_r5 = 0, v_r10 = 0, v_r9 = 0, v_r2p = 0;
    bit  psel = 0, pwe = 1, poe = 1, pdq = 0, prv = 0;
    logic [AW-1:0] waddr;
    logic [15:0]   wdat;

    always @(negedge clk) begin
        bit sel;
        if (rst_n) begin
            sel = !mem_ce_n && mem_ce2;
            if (sel) begin
                if (!psel) begin
                    chk(desel_run >= GAPC, "R7", "deselect length", desel_run, GAPC);
                    sel_starts++;
                end
                sel_run++;
                desel_run = 0;
            end else begin
                if (psel) begin
                    chk(sel_run <= SELM, "R6", "select run", sel_run, SELM);
                    chk(!req_ready, "R7", "ready in gap", int'(req_ready), 0);
                    if (sel_run > max_run) max_run = sel_run;
                end
                sel_run = 0;
                desel_run++;
            end
            if (!mem_we_n) begin
                if (we_run == 0) begin waddr = mem_addr; wdat = mem_dq_o; end
                else if (mem_addr != waddr || mem_dq_o != wdat) v_r9++;
                we_run++;
            end else if (!pwe) begin
                chk(we_run == WRC, "R3", "we width", we_run, WRC);
                chk(mem_dq_oe && mem_lb_n && mem_ub_n, "R3", "release cycle",
                    int'({mem_dq_oe, mem_lb_n, mem_ub_n}), 7);
                chk(mem_addr == waddr && mem_dq_o == wdat, "R3", "hold in release",
                    int'(mem_dq_o), int'(wdat));
                we_run = 0;
            end
            if (!mem_oe_n) oe_run++;
            else if (!poe) begin
                chk(oe_run == RDC, "R2", "oe width", oe_run, RDC);
                oe_run = 0;
            end
            if (mem_dq_oe && !pdq)
                chk(poe && mem_oe_n, "R5", "turnaround", int'(poe), 1);
            if (mem_dq_oe && !mem_oe_n) v_r5++;
            if (mem_dq_oe && mem_we_n && !pwe == 1'b0 && !(mem_lb_n && mem_ub_n)) v_r5++;
            if (!mem_we_n && !mem_oe_n) v_r10++;
            if (rsp_valid && prv) v_r2p++;
            psel = sel; pwe = mem_we_n; poe = mem_oe_n; pdq = mem_dq_oe; prv = rsp_valid;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int n, s0;
        logic [15:0] w;
        void'($urandom(32'd4711));
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; req_be = 2'b00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n
            && !mem_dq_oe && !req_ready, "R1", "reset pins",
            int'({mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}), 6'b101100);
        rst_n = 1'b1;
        n = 0;
        while (!req_ready && n < 1000) begin
            if (!mem_ce_n || mem_ce2) v_r5 = v_r5;
            chk(mem_ce_n && !mem_ce2, "R1", "deselected during init", int'(mem_ce_n), 1);
            n++;
            @(negedge clk);
        end
        chk(n == INIT, "R1", "init length", n, INIT);

        // R3/R2 basic write then read
        issue(1, 32'h12345, 16'hA55A, 2'b11);
        idle(6);
        issue(0, 32'h12345, 16'h0, 2'b11);
        idle(10);

        // R4 lane mapping
        issue(1, 32'h10, 16'h1122, 2'b11);
        idle(6);
        issue(1, 32'h10, 16'hFF33, 2'b01);
        idle(6);
        chk(prd(32'h10) == 16'h1133, "R4", "low lane only", int'(prd(32'h10)), 16'h1133);
        issue(1, 32'h10, 16'h77FF, 2'b10);
        idle(6);
        chk(prd(32'h10) == 16'h7733, "R4", "high lane only", int'(prd(32'h10)), 16'h7733);
        issue(0, 32'h10, 16'h0, 2'b10);
        idle(10);
        issue(0, 32'h10, 16'h0, 2'b01);
        idle(10);

        // R8 back-to-back reads stay in one select period
        s0 = sel_starts;
        issue(0, 32'h10, 16'h0, 2'b11);
        issue(0, 32'h12345, 16'h0, 2'b11);
        issue(0, 32'h10, 16'h0, 2'b11);
        idle(12);
        chk(sel_starts - s0 == 1, "R8", "selects for 3 chained reads", sel_starts - s0, 1);

        // R6 twelve chained writes need exactly one forced gap
        s0 = sel_starts;
        max_run = 0;
        for (int i = 0; i < 12; i++)
            issue(1, 32'h40 + i, 16'(16'h0C00 + i * 16'h0101), 2'b11);
        idle(12);
        chk(sel_starts - s0 == 2, "R6", "selects for 12 chained writes", sel_starts - s0, 2);
        chk(max_run == SELM, "R6", "longest run", max_run, SELM);
        for (int i = 0; i < 12; i++) begin
            w = prd(32'h40 + i);
            chk(w == 16'(16'h0C00 + i * 16'h0101), "R6", "burst data kept",
                int'(w), 16'h0C00 + i * 16'h0101);
        end
        for (int i = 0; i < 12; i++) issue(0, 32'h40 + i, 16'h0, 2'b11);
        idle(12);

        // random mix
        for (int i = 0; i < 300; i++) begin
            int a;
            a = ($urandom % 4 == 0) ? int'(32'h7FFF0 + ($urandom % 16)) : int'($urandom % 16);
            issue($urandom % 2 == 1, a, 16'($urandom), 2'($urandom % 3 + 1));
            idle(int'($urandom % 3));
        end
        idle(20);

        chk(rq.size() == 0, "R2", "responses outstanding", rq.size(), 0);
        chk(v_r2p == 0, "R2", "rsp_valid longer than one cycle", v_r2p, 0);
        chk(v_r5 == 0, "R5", "bus drive overlaps output enable", v_r5, 0);
        chk(v_r9 == 0, "R9", "addr or data moved under we", v_r9, 0);
        chk(v_r10 == 0, "R10", "we and oe low together", v_r10, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule